// File: doc/BRIEF.md
# Configurable-Frame Serial Transmitter

This block turns one data word at a time into an asynchronous serial frame on a single line that rests high. Software-style configuration inputs select, while the block runs, how many data bits a frame carries (5 to 9), whether and how a parity bit is formed, and whether one or two stop bits close the frame. A 16-bit prescale value sets the bit time to (prescale+1)×16 clock cycles.

Words come from an external transmit queue through a valid/ready handshake. The block accepts a word only when it is idle and both its global enable and its transmit enable are high. It then owns the line until the last stop bit has run its full time. All frame settings, including the prescale value, are captured when the word is accepted, so later changes apply only from the next frame. A busy output marks the span from acceptance to the end of the final stop bit.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset the line output is 1, busy is 0, and in_ready is 1 whenever enable and tx_enable are both 1. While busy is 0 the line is 1.
- R2: A frame goes out in this order: a start bit of value 0, the data bits least significant first, the parity bit if one is selected, then the stop bits of value 1. The start bit appears on the line in the cycle after the accepting clock edge.
- R3: word_len selects 5 to 9 data bits. Codes below 5 send 5 bits and codes above 9 send 9 bits. Data bits above the selected length are not sent.
- R4: parity_sel selects the parity bit. 3'b000 means no parity bit. 3'b001 means odd parity, so the total count of ones over data and parity is odd. 3'b010 means even parity. 3'b100 sends a parity bit fixed at 0 and 3'b101 sends one fixed at 1. Every other code means no parity bit.
- R5: two_stop = 1 sends two stop bits and two_stop = 0 sends one.
- R6: Every bit of the frame lasts exactly (prescale+1)×16 clock cycles. Busy falls exactly that many cycles times the number of frame bits after the accepting edge.
- R7: in_ready is 0 whenever enable or tx_enable is 0. A word offered at such a time is not accepted, and the line stays at 1.
- R8: From the accepting edge until the last stop bit has completed, busy is 1 and in_ready is 0. A word held valid during this span is not taken.
- R9: word_len, parity_sel, two_stop and prescale are captured at the accepting edge. Changing them mid-frame does not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Global enable |
| tx_enable | input | 1 | Transmit enable |
| prescale | input | 16 | Bit-time prescale value |
| word_len | input | 4 | Data bit count code |
| parity_sel | input | 3 | Parity mode code |
| two_stop | input | 1 | 1: two stop bits, 0: one |
| in_data | input | 9 | Word offered by the queue |
| in_valid | input | 1 | Queue has a word |
| in_ready | output | 1 | Word accepted on this edge when valid |
| tx_line | output | 1 | Serial output, idle high |
| busy | output | 1 | Frame in progress |

## Verification
The bench builds the block with its default parameters: a 16-bit prescale, 16 clock cycles per prescale step and 9-bit maximum words. This makes every word length from 5 to 9 reachable, along with all parity codes, including the undefined ones. Most frames use prescale 0, which keeps bits 16 cycles long so that many frames fit in a short run. One frame uses prescale 2 to show that the divider scales the bit time. Sampling in the middle of each bit and just before and after the closing edge pins the bit time to the exact cycle.

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
  parameter int PRE_W = 16,
  parameter int OVS   = 16,
  parameter int MAX_W = 9,
  parameter int MIN_W = 5,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tx_enable,
  input  logic [PRE_W-1:0] prescale,
  input  logic [LEN_W-1:0] word_len,
  input  logic [2:0]       parity_sel,
  input  logic             two_stop,
  input  logic [MAX_W-1:0] in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             tx_line,
  output logic             busy
);
  localparam int OVS_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int CNT_W = $clog2(MAX_W + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t              st;
  logic [MAX_W-1:0] sh;
  logic [CNT_W-1:0] bits_left;
  logic             par_en_q, par_bit_q, stop2_q, stop_left;
  logic [PRE_W-1:0] pr_q, pre_cnt;
  logic [OVS_W-1:0] os_cnt;

  logic [CNT_W-1:0] wl_eff;
  logic [MAX_W-1:0] masked;
  logic             par_en, par_bit, accept, pre_end, bit_end;

  assign in_ready = (st == S_IDLE) && enable && tx_enable;
  assign accept   = in_ready && in_valid;
  assign busy     = (st != S_IDLE);
  assign pre_end  = (pre_cnt == pr_q);
  assign bit_end  = pre_end && (os_cnt == OVS_W'(OVS - 1));

  always_comb begin
    if (word_len < LEN_W'(MIN_W))      wl_eff = CNT_W'(MIN_W);
    else if (word_len > LEN_W'(MAX_W)) wl_eff = CNT_W'(MAX_W);
    else                               wl_eff = CNT_W'(word_len);
  end

  always_comb begin
    for (int i = 0; i < MAX_W; i++)
      masked[i] = in_data[i] && (i < int'(wl_eff));
  end

  always_comb begin
    par_en  = 1'b1;
    par_bit = 1'b0;
    case (parity_sel)
      3'b001:  par_bit = ~^masked;
      3'b010:  par_bit = ^masked;
      3'b100:  par_bit = 1'b0;
      3'b101:  par_bit = 1'b1;
      default: par_en  = 1'b0;
    endcase
  end

  always_comb begin
    case (st)
      S_START: tx_line = 1'b0;
      S_DATA:  tx_line = sh[0];
      S_PAR:   tx_line = par_bit_q;
      default: tx_line = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      sh        <= '0;
      bits_left <= '0;
      par_en_q  <= 1'b0;
      par_bit_q <= 1'b0;
      stop2_q   <= 1'b0;
      stop_left <= 1'b0;
      pr_q      <= '0;
      pre_cnt   <= '0;
      os_cnt    <= '0;
    end else if (accept) begin
      st        <= S_START;
      sh        <= masked;
      bits_left <= wl_eff;
      par_en_q  <= par_en;
      par_bit_q <= par_bit;
      stop2_q   <= two_stop;
      pr_q      <= prescale;
      pre_cnt   <= '0;
      os_cnt    <= '0;
    end else if (st != S_IDLE) begin
      if (pre_end) begin
        pre_cnt <= '0;
        os_cnt  <= (os_cnt == OVS_W'(OVS - 1)) ? '0 : os_cnt + 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
      if (bit_end) begin
        case (st)
          S_START: st <= S_DATA;
          S_DATA: begin
            sh        <= sh >> 1;
            bits_left <= bits_left - 1'b1;
            if (bits_left == CNT_W'(1)) begin
              st        <= par_en_q ? S_PAR : S_STOP;
              stop_left <= stop2_q;
            end
          end
          S_PAR: begin
            st        <= S_STOP;
            stop_left <= stop2_q;
          end
          S_STOP: begin
            if (stop_left) stop_left <= 1'b0;
            else           st        <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_frame_tx_chk.sv
module serial_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic tx_enable,
  input logic in_valid,
  input logic in_ready,
  input logic tx_line,
  input logic busy
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_line);

  assert_accept_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (busy && !tx_line));

  assert_rise_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !tx_line);

  assert_last_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tx_line));

  assert_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (enable && tx_enable));

  assert_no_take_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);
endmodule

bind serial_frame_tx serial_frame_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .tx_enable(tx_enable),
  .in_valid(in_valid), .in_ready(in_ready), .tx_line(tx_line), .busy(busy)
);

// File: tb/serial_frame_tx_bench.sv
`timescale 1ns/1ps
module serial_frame_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b1, tx_enable = 1'b1;
  logic [15:0] prescale = '0;
  logic [3:0] word_len = 4'd8;
  logic [2:0] parity_sel = 3'b000;
  logic       two_stop = 1'b0;
  logic [8:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_ready, tx_line, busy;
  int n_checks = 0, n_fail = 0;

  always #10 clk = ~clk;

  serial_frame_tx u_serial_frame_tx (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tx_enable(tx_enable),
    .prescale(prescale), .word_len(word_len), .parity_sel(parity_sel),
    .two_stop(two_stop), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .tx_line(tx_line), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int build(input logic [8:0] d, input int wl, input int par,
                               input bit s2, output logic [15:0] fr);
    int n = 0, w, ones = 0;
    fr = '1;
    w = (wl < 5) ? 5 : (wl > 9) ? 9 : wl;
    fr[n++] = 1'b0;
    for (int i = 0; i < w; i++) begin
      fr[n++] = d[i];
      ones += d[i];
    end
    case (par)
      1: fr[n++] = (ones % 2 == 0);
      2: fr[n++] = (ones % 2 == 1);
      4: fr[n++] = 1'b0;
      5: fr[n++] = 1'b1;
      default: ;
    endcase
    fr[n++] = 1'b1;
    if (s2) fr[n++] = 1'b1;
    return n;
  endfunction

  task automatic run_frame(input logic [8:0] d, input int wl, input int par,
                           input bit s2, input int pr, input bit disturb,
                           input string req);
    logic [15:0] fr, got;
    int nb, nn, bad = 0, rdy_bad = 0;
    nb = build(d, wl, par, s2, fr);
    nn = (pr + 1) * 16;
    got = '1;
    @(negedge clk);
    word_len = 4'(wl); parity_sel = 3'(par); two_stop = s2;
    prescale = 16'(pr); in_data = d; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    if (disturb) begin
      word_len = 4'd5; parity_sel = 3'b101; two_stop = ~s2;
      prescale = 16'(pr + 3); in_data = ~d;
    end else begin
      in_valid = 1'b0;
    end
    for (int k = 0; k < nb; k++) begin
      repeat (k == 0 ? nn / 2 : nn) @(negedge clk);
      got[k] = tx_line;
      if (tx_line !== fr[k]) bad++;
      if (in_ready !== 1'b0 || busy !== 1'b1) rdy_bad++;
    end
    chk(bad == 0, req, "frame bits", int'(got), int'(fr));
    chk(rdy_bad == 0, "R8", "ready low/busy high mid-frame", rdy_bad, 0);
    repeat (nn / 2 - 1) @(negedge clk);
    chk(busy === 1'b1, "R6", "busy just before frame end", busy, 1);
    @(negedge clk);
    chk(busy === 1'b0 && tx_line === 1'b1, "R6", "idle right after frame end",
        {busy, tx_line}, 1);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk(tx_line === 1'b1 && busy === 1'b0 && in_ready === 1'b1, "R1",
        "reset state {tx,busy,ready}", {tx_line, busy, in_ready}, 3'b101);
  endtask

  task automatic t_gate(input bit e, input bit t);
    int bad = 0;
    @(negedge clk);
    enable = e; tx_enable = t; in_valid = 1'b1; in_data = 9'h000;
    repeat (40) begin
      @(negedge clk);
      if (in_ready !== 1'b0 || tx_line !== 1'b1 || busy !== 1'b0) bad++;
    end
    chk(bad == 0, "R7", "gated: no accept, line high", bad, 0);
    in_valid = 1'b0; enable = 1'b1; tx_enable = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1 && busy === 1'b0, "R7", "ready after re-enable",
        in_ready, 1);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_frame(9'h0A5, 8, 0, 0, 0, 0, "R2");
    run_frame(9'h013, 5, 1, 0, 0, 0, "R3 R4 odd");
    run_frame(9'h1C3, 9, 2, 1, 0, 0, "R3 R4 R5 even");
    run_frame(9'h05A, 7, 4, 0, 0, 0, "R4 fixed0");
    run_frame(9'h03F, 6, 5, 1, 0, 0, "R4 fixed1");
    run_frame(9'h0B1, 8, 3, 0, 0, 0, "R4 undefined code");
    run_frame(9'h0B1, 8, 7, 1, 0, 0, "R4 undefined code");
    run_frame(9'h1FF, 2, 1, 0, 0, 0, "R3 short clamp");
    run_frame(9'h155, 13, 2, 0, 0, 0, "R3 long clamp");
    run_frame(9'h0E4, 8, 1, 1, 2, 0, "R6 prescale 2");
    run_frame(9'h1A6, 9, 0, 0, 1, 1, "R9 R8 mid-frame change");
    t_gate(1'b0, 1'b1);
    t_gate(1'b1, 1'b0);
    run_frame(9'h06C, 8, 2, 0, 0, 0, "R2 after gating");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule